// File: doc/BRIEF.md
# External Interrupt Pin Detector

The block watches one non-maskable interrupt pin and a parameterised set of maskable request pins (six by default). Every pin is brought into the clock domain through a two-stage synchroniser. Each maskable line then runs its own detector, which can be set to low level, falling edge, rising edge or both edges. A detection sets a sticky per-line flag. Software clears that flag through the register port. The flag, gated by a per-line enable, forms the line's request output.

The non-maskable pin has its own edge polarity select. It produces a one-cycle request pulse that no enable bit can block. A wake output is raised whenever any maskable request or the non-maskable pulse is active, so a standby controller can restart the clock tree. Each maskable line also holds a 3-bit priority value. This value is only stored and exposed for an external arbiter.

Register access uses a single-cycle write strobe and a combinational read mux on a 2-bit word address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables, sense fields and priority fields are 0, the non-maskable select is 0 (falling edge), and `irq_req_o`, `nmi_req_o` and `wake_o` are low.
- R2: With sense code 00 (low level), a line's flag is set on every clock edge while its synchronised pin is low. A pin value sampled at clock edge k affects the flag at edge k+2.
- R3: With sense code 01, the flag is set once for each high-to-low transition of the pin, with the same latency as in R2.
- R4: With sense code 10, the flag is set only on a low-to-high transition. A pin that stays steady never sets the flag.
- R5: With sense code 11, both transition directions set the flag.
- R6: Writing word address 2 clears each flag whose write-data bit is 0 and leaves each flag whose bit is 1. If a detection and a clear land on the same cycle, the flag stays set. In low-level mode the flag therefore cannot be cleared while the pin is low.
- R7: `irq_req_o[n]` is high exactly when flag n and enable n are both 1. A disabled line still sets its flag, and the flag can be read at address 2.
- R8: The non-maskable request is a one-cycle pulse on `nmi_req_o`. It fires on the falling edge when the select bit is 0 and on the rising edge when the select bit is 1, with the R2 latency, and no enable affects it.
- R9: `wake_o` is high exactly when any bit of `irq_req_o` is high or `nmi_req_o` is high.
- R10: Word address 3 holds a 3-bit priority per line, with line n at bits [3n+2:3n]. It reads back as written and is driven on `prio_o`.
- R11: The word addresses are: 0 for the sense fields (line n at bits [2n+1:2n]); 1 for the enables in bits [N-1:0] with the non-maskable select at bit 8; 2 for the flags; 3 for the priorities. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin (asynchronous) |
| irq_pin_i | input | N_IRQ | Maskable interrupt pins (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data (combinational) |
| irq_req_o | output | N_IRQ | Per-line gated requests |
| nmi_req_o | output | 1 | Non-maskable request pulse |
| wake_o | output | 1 | Standby exit request |
| prio_o | output | 3*N_IRQ | Stored per-line priority levels |

## Verification
The assertions assume that pins stay high while reset is asserted, so the synchroniser's high reset value matches the pin level and no false edge appears on release. The bench therefore holds every pin high until reset has been deasserted for several cycles. The assertions also assume that a sense field does not change in the same cycle as a pin transition. The bench only rewrites sense fields during quiet stretches of the directed phases, and again in the random phase. In the random phase, pin toggles and clear writes are driven from a shift-register sequence. These drive set/clear collisions and back-to-back edges through a reference model that the bench updates on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned PRIO_W     = 3;
  localparam int unsigned NMI_SEL_BIT = 8;
  localparam logic [1:0]  ADDR_SENSE = 2'd0;
  localparam logic [1:0]  ADDR_EN    = 2'd1;
  localparam logic [1:0]  ADDR_STAT  = 2'd2;
  localparam logic [1:0]  ADDR_PRIO  = 2'd3;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // idle-high reset so released pins do not look like edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_s_i,
  input  sense_e sense_i,
  input  logic   en_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o
);
  logic prev_q, flag_q, set, fall, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s_i;
  end

  assign fall = prev_q & ~pin_s_i;
  assign rise = ~prev_q & pin_s_i;

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  set = ~pin_s_i;
      SENSE_FALL: set = fall;
      SENSE_RISE: set = rise;
      default:    set = fall | rise;
    endcase
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = flag_q & en_i;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> flag_q);  // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !flag_q);  // R6
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set));  // R3
  AST_RISE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_RISE && pin_s_i == prev_q && !flag_q) |=> !flag_q);  // R4
endmodule

// File: rtl/ext_irq_nmi.sv
module ext_irq_nmi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic rise_sel_i,
  output logic req_o
);
  logic prev_q, req_q, hit;

  assign hit = rise_sel_i ? (~prev_q & pin_s_i) : (prev_q & ~pin_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      req_q  <= hit;
    end
  end

  assign req_o = req_q;

  AST_NMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);  // R8
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     nmi_pin_i,
  input  logic [N_IRQ-1:0]         irq_pin_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_IRQ-1:0]         irq_req_o,
  output logic                     nmi_req_o,
  output logic                     wake_o,
  output logic [PRIO_W*N_IRQ-1:0]  prio_o
);
  localparam int unsigned SENSE_W = 2 * N_IRQ;
  localparam int unsigned PRIOS_W = PRIO_W * N_IRQ;

  logic [SENSE_W-1:0] sense_q;
  logic [N_IRQ-1:0]   en_q, flag, clr;
  logic [PRIOS_W-1:0] prio_q;
  logic               nmi_rise_q;
  logic [N_IRQ:0]     pins_s;

  ext_irq_sync #(.WIDTH(N_IRQ + 1), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({nmi_pin_i, irq_pin_i}),
    .sync_o  (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q    <= '0;
      en_q       <= '0;
      prio_q     <= '0;
      nmi_rise_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_SENSE: sense_q <= wdata_i[SENSE_W-1:0];
        ADDR_EN: begin
          en_q       <= wdata_i[N_IRQ-1:0];
          nmi_rise_q <= wdata_i[NMI_SEL_BIT];
        end
        ADDR_PRIO:  prio_q <= wdata_i[PRIOS_W-1:0];
        default: ;
      endcase
    end
  end

  // zero bits in a status write clear the matching flags
  assign clr = (wr_en_i && addr_i == ADDR_STAT) ? ~wdata_i[N_IRQ-1:0] : '0;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    ext_irq_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_s_i (pins_s[i]),
      .sense_i (sense_e'(sense_q[2*i +: 2])),
      .en_i    (en_q[i]),
      .clr_i   (clr[i]),
      .flag_o  (flag[i]),
      .req_o   (irq_req_o[i])
    );
  end

  ext_irq_nmi u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_s_i    (pins_s[N_IRQ]),
    .rise_sel_i (nmi_rise_q),
    .req_o      (nmi_req_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SENSE: rdata_o[SENSE_W-1:0] = sense_q;
      ADDR_EN: begin
        rdata_o[N_IRQ-1:0]   = en_q;
        rdata_o[NMI_SEL_BIT] = nmi_rise_q;
      end
      ADDR_STAT:  rdata_o[N_IRQ-1:0]  = flag;
      default:    rdata_o[PRIOS_W-1:0] = prio_q;
    endcase
  end

  assign wake_o = nmi_req_o | (|irq_req_o);
  assign prio_o = prio_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0 && !(wr_en_i && addr_i == ADDR_EN)) |=> irq_req_o == '0);  // R7
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int N = 6;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_pin = 1'b1;
  logic [N-1:0] irq_pins = '1;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0] irq_req;
  logic nmi_req, wake;
  logic [3*N-1:0] prio;

  int checks = 0, errors = 0;
  string cur_tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(nmi_pin), .irq_pin_i(irq_pins),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_req_o(irq_req), .nmi_req_o(nmi_req), .wake_o(wake), .prio_o(prio)
  );

  // reference model: pin history per line, index N is the non-maskable pin
  bit hist [N+1][3];
  bit m_flag [N];
  bit m_en [N];
  int m_sense [N];
  int m_prio [N];
  bit m_nmi_rise, m_nmi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= N; i++) for (int k = 0; k < 3; k++) hist[i][k] = 1;
      for (int i = 0; i < N; i++) begin
        m_flag[i] = 0; m_en[i] = 0; m_sense[i] = 0; m_prio[i] = 0;
      end
      m_nmi_rise = 0; m_nmi = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit s, p, hit, clr;
        s = hist[i][1]; p = hist[i][2];
        case (m_sense[i])
          0: hit = !s;
          1: hit = p && !s;
          2: hit = !p && s;
          default: hit = p != s;
        endcase
        clr = wr_en && addr == 2 && !wdata[i];
        if (hit) m_flag[i] = 1;
        else if (clr) m_flag[i] = 0;
      end
      m_nmi = m_nmi_rise ? (!hist[N][2] && hist[N][1]) : (hist[N][2] && !hist[N][1]);
      for (int i = 0; i <= N; i++) begin
        hist[i][2] = hist[i][1];
        hist[i][1] = hist[i][0];
        hist[i][0] = (i == N) ? nmi_pin : irq_pins[i];
      end
      if (wr_en) begin
        case (addr)
          2'd0: for (int i = 0; i < N; i++) m_sense[i] = int'(wdata[2*i +: 2]);
          2'd1: begin
            for (int i = 0; i < N; i++) m_en[i] = wdata[i];
            m_nmi_rise = wdata[8];
          end
          2'd3: for (int i = 0; i < N; i++) m_prio[i] = int'(wdata[3*i +: 3]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] exp_req();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_flag[i] & m_en[i];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    logic [DW-1:0] d = '0;
    for (int i = 0; i < N; i++) begin
      case (a)
        2'd0: d[2*i +: 2] = 2'(m_sense[i]);
        2'd1: d[i] = m_en[i];
        2'd2: d[i] = m_flag[i];
        default: d[3*i +: 3] = 3'(m_prio[i]);
      endcase
    end
    if (a == 2'd1) d[8] = m_nmi_rise;
    return d;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] er;
      logic ew;
      er = exp_req();
      ew = m_nmi | (|er);
      checks++;
      if (irq_req !== er || nmi_req !== m_nmi || wake !== ew) begin
        errors++;
        $display("FAIL %s (R7/R8/R9) req=%b nmi=%b wake=%b expected req=%b nmi=%b wake=%b",
                 cur_tag, irq_req, nmi_req, wake, er, m_nmi, ew);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    #1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    #1; wr_en = 0;
  endtask

  task automatic rd_check(input logic [1:0] a, input string tag);
    @(negedge clk);
    #1; addr = a;
    #1;
    checks++;
    if (rdata !== exp_read(a)) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp_read(a));
    end
  endtask

  task automatic flag_check(input int line, input bit want, input string tag);
    @(negedge clk);
    #1; addr = 2;
    #1;
    checks++;
    if (rdata[line] !== want || m_flag[line] !== want) begin
      errors++;
      $display("FAIL %s line=%0d flag actual=%b expected=%b", tag, line, rdata[line], want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    tick(3);
    rst_n = 1;
    tick(4);
    // R1 reset state
    cur_tag = "R1";
    checks++;
    if (irq_req !== '0 || nmi_req !== 0 || wake !== 0 || prio !== '0) begin
      errors++;
      $display("FAIL R1 outputs req=%b nmi=%b wake=%b prio=%h expected all 0", irq_req, nmi_req, wake, prio);
    end
    for (int a = 0; a < 4; a++) rd_check(2'(a), "R1");

    // R10 / R11 priority storage and map
    cur_tag = "R10";
    wr(3, 32'h0002_C6B5);
    rd_check(3, "R10");
    checks++;
    if (prio !== 18'h2C6B5) begin
      errors++;
      $display("FAIL R10 prio_o actual=%h expected=%h", prio, 18'h2C6B5);
    end
    cur_tag = "R11";
    wr(0, 32'hFFFF_0E4);
    rd_check(0, "R11");
    wr(0, 32'h0);
    wr(1, 32'hFFFF_FEFF);
    rd_check(1, "R11");

    // R2 low level: flag holds while low, clears only once pin is high
    cur_tag = "R2";
    wr(1, 32'h3F);
    irq_pins[0] = 0;
    tick(4);
    flag_check(0, 1, "R2");
    cur_tag = "R6";
    wr(2, 32'h3E);
    flag_check(0, 1, "R6");
    irq_pins[0] = 1;
    tick(4);
    wr(2, 32'h3E);
    flag_check(0, 0, "R6");

    // R3 / R4 / R5 edge modes: line1 fall, line2 rise, line3 both, line5 both
    cur_tag = "R3";
    wr(0, {20'd0, 2'b11, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00});
    wr(2, 32'h0);
    tick(3);
    flag_check(1, 0, "R3");
    irq_pins[3:1] = 3'b000;
    tick(4);
    flag_check(1, 1, "R3");
    flag_check(2, 0, "R4");
    flag_check(3, 1, "R5");
    cur_tag = "R4";
    wr(2, 32'h0);
    tick(3);
    flag_check(1, 0, "R3");
    irq_pins[3:1] = 3'b111;
    tick(4);
    flag_check(2, 1, "R4");
    flag_check(1, 0, "R3");
    flag_check(3, 1, "R5");

    // R7 disabled line still flags
    cur_tag = "R7";
    wr(1, 32'h0F);
    wr(0, {20'd0, 2'b11, 2'b01, 12'd0});
    wr(2, 32'h0);
    irq_pins[4] = 0;
    tick(4);
    flag_check(4, 1, "R7");
    checks++;
    if (irq_req[4] !== 0) begin
      errors++;
      $display("FAIL R7 irq_req[4] actual=%b expected=0", irq_req[4]);
    end
    irq_pins[4] = 1;

    // R6 set/clear collisions at sweeping offsets
    cur_tag = "R6";
    wr(1, 32'h3F);
    for (int off = 0; off < 6; off++) begin
      irq_pins[5] = ~irq_pins[5];
      tick(off);
      wr(2, 32'h0);
      tick(3);
      rd_check(2, "R6");
    end

    // R8 non-maskable edges, enables cleared
    cur_tag = "R8";
    wr(1, 32'h0);
    nmi_pin = 0; tick(5);
    nmi_pin = 1; tick(5);
    wr(1, 32'h100);
    nmi_pin = 0; tick(5);
    nmi_pin = 1; tick(5);
    rd_check(1, "R8");

    // R9 random mix of modes, toggles and clears
    cur_tag = "R9";
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq_pins = irq_pins ^ lfsr[5:0];
      if (lfsr[9:7] == 3'b101) nmi_pin = ~nmi_pin;
      if (c % 97 == 0) begin
        wr(0, {20'd0, lfsr[11:0]});
        wr(1, {23'd0, lfsr[12], 2'b0, lfsr[15:10]});
      end else if (lfsr[15:13] == 3'b000) begin
        wr(2, {26'd0, lfsr[6:1]});
      end
    end
    rd_check(2, "R9");

    done = 1;
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule